// File: doc/BRIEF.md
# Zigzag Scan Address Sequencer

This block produces the addresses of an 8x8 data array in zigzag order, one per accepted beat, with no instruction stream. A start pulse loads the data counter with the corner cell (1,1). A small program of scan primitives then moves the counter. Each primitive adds a fixed signed step vector to the (x,y) counter. It repeats that step up to a loop limit and ends early once a coordinate reaches an edge.

The program runs in three parts. The first is a half-pattern macro: one east step, then three passes of the group south-west, south, north-east, east. The second is a single south-west sweep across the main anti-diagonal. The third replays the half-pattern with its primitives in reverse order, mirrored: each early-exit test looks at the other coordinate against the far edge. The only arithmetic is step addition and loop counting.

The downstream consumer takes the coordinates and the row-major linear address through a valid/ready handshake. A single-cycle done pulse marks the end of the scan.

Top module: `zz_scan_seq`

## Requirements
- R1: While rst_n is low, valid and done are low and start has no effect; after reset the block stays idle with valid low.
- R2: A start pulse seen in the idle state makes valid high on the next cycle with x=1, y=1 and addr=0.
- R3: While valid is high, x and y lie in 1..8 and addr equals (y-1)*8+(x-1).
- R4: Two consecutive accepted beats differ by at most one in each coordinate and never name the same cell.
- R5: The emitted order is the zigzag order. Cells are sorted by d=(x-1)+(y-1) ascending. Within an even d, x ascends; within an odd d, x descends.
- R6: A scan emits exactly 64 beats and covers every cell exactly once. The last beat is (8,8).
- R7: With ready held high, a new address is accepted every cycle, so all 64 beats take 64 cycles. While valid is high and ready is low, valid, x, y and addr hold their values.
- R8: In the cycle after the (8,8) beat is accepted, done is high for exactly one cycle and valid is low.
- R9: A start pulse during a scan is ignored. The order and count of beats are unchanged.
- R10: After done, a new start pulse replays the identical 64-beat sequence from (1,1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a scan when the block is idle |
| ready | input | 1 | Consumer accepts the current beat at the clock edge |
| x | output | CW (4) | Column coordinate, 1-based |
| y | output | CW (4) | Row coordinate, 1-based |
| addr | output | AW (6) | Row-major linear address (y-1)*GRID+(x-1) |
| valid | output | 1 | x, y and addr carry a beat |
| done | output | 1 | One-cycle pulse after the final beat is accepted |

## Verification
A wrong slot index, iteration count or phase shows up on the next accepted beat. Either the coordinate jumps by more than one cell, or it steps off the grid because a primitive overran its edge. The neighbour assertion catches this in the same cycle. An early-exit test aimed at the wrong edge or coordinate can keep every step local and still break the order. Comparing the scan with the diagonal-sum reference exposes it at the first differing beat. A fault in the phase sequencing after the last primitive shows as a missing or misplaced done pulse, one cycle after (8,8).

// File: rtl/zz_scan_pkg.sv
package zz_scan_pkg;

   // Scan primitive kinds (step vectors in comments)
   typedef enum logic [1:0] {
      PRIM_EAST  = 2'd0,   // [+1, 0], single step
      PRIM_SOUTH = 2'd1,   // [ 0,+1], single step
      PRIM_NE    = 2'd2,   // [+1,-1], repeated with edge exit
      PRIM_SW    = 2'd3    // [-1,+1], repeated with edge exit
   } prim_e;

   // Program phases
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_FWD  = 3'd1,      // half-pattern, forward
      PH_MID  = 3'd2,      // single diagonal sweep
      PH_REV  = 3'd3,      // half-pattern, reversed and mirrored
      PH_LAST = 3'd4       // final beat on the output
   } phase_e;

endpackage

// File: rtl/zz_prim_decode.sv
module zz_prim_decode
   import zz_scan_pkg::*;
#(
   parameter int SLOT_W = 4
) (
   input  logic [SLOT_W-1:0] slot,
   output prim_e             prim
);

   // Slot 0 is the lead-in east step; slots 1.. repeat SW, S, NE, E.
   logic [1:0] grp_pos;

   always_comb begin
      grp_pos = slot[1:0] - 2'd1;
      if (slot == '0) begin
         prim = PRIM_EAST;
      end else begin
         case (grp_pos)
            2'd0:    prim = PRIM_SW;
            2'd1:    prim = PRIM_SOUTH;
            2'd2:    prim = PRIM_NE;
            default: prim = PRIM_EAST;
         endcase
      end
   end

endmodule

// File: rtl/zz_step_unit.sv
module zz_step_unit
   import zz_scan_pkg::*;
#(
   parameter int GRID = 8,
   parameter int CW   = 4
) (
   input  logic [CW-1:0] x,
   input  logic [CW-1:0] y,
   input  prim_e         prim,
   input  logic          mirror,
   output logic [CW-1:0] nx,
   output logic [CW-1:0] ny,
   output logic          edge_hit
);

   localparam logic [CW-1:0] ONE  = CW'(1);
   localparam logic [CW-1:0] EDGE = CW'(GRID);

   always_comb begin
      nx       = x;
      ny       = y;
      edge_hit = 1'b1;
      case (prim)
         PRIM_EAST:  nx = x + ONE;
         PRIM_SOUTH: ny = y + ONE;
         PRIM_NE: begin
            nx       = x + ONE;
            ny       = y - ONE;
            // mirrored replay tests the other coordinate at the far edge
            edge_hit = mirror ? (nx == EDGE) : (ny == ONE);
         end
         default: begin
            nx       = x - ONE;
            ny       = y + ONE;
            edge_hit = mirror ? (ny == EDGE) : (nx == ONE);
         end
      endcase
   end

endmodule

// File: rtl/zz_seq_ctrl.sv
module zz_seq_ctrl
   import zz_scan_pkg::*;
#(
   parameter int GRID      = 8,
   parameter int CW        = 4,
   parameter int SLOT_W    = 4,
   parameter int ITER_W    = 3,
   parameter int LAST_SLOT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ready,
   input  prim_e             prim,
   input  logic [CW-1:0]     nx,
   input  logic [CW-1:0]     ny,
   input  logic              edge_hit,
   output phase_e            phase,
   output logic [SLOT_W-1:0] slot,
   output logic [CW-1:0]     x,
   output logic [CW-1:0]     y,
   output logic              valid,
   output logic              done
);

   localparam logic [ITER_W-1:0] NE_LAST = ITER_W'(GRID - 3);
   localparam logic [ITER_W-1:0] SW_LAST = ITER_W'(GRID - 2);
   localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(LAST_SLOT);

   logic [ITER_W-1:0] iter;
   logic [ITER_W-1:0] iter_last;
   logic              prim_fin;

   always_comb begin
      case (prim)
         PRIM_NE: iter_last = NE_LAST;
         PRIM_SW: iter_last = SW_LAST;
         default: iter_last = '0;
      endcase
      prim_fin = edge_hit || (iter == iter_last);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         slot  <= '0;
         iter  <= '0;
         x     <= CW'(1);
         y     <= CW'(1);
         valid <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (start) begin
                  x     <= CW'(1);
                  y     <= CW'(1);
                  slot  <= '0;
                  iter  <= '0;
                  valid <= 1'b1;
                  phase <= PH_FWD;
               end
            end
            PH_LAST: begin
               if (ready) begin
                  valid <= 1'b0;
                  done  <= 1'b1;
                  phase <= PH_IDLE;
               end
            end
            default: begin
               if (ready) begin
                  x <= nx;
                  y <= ny;
                  if (prim_fin) begin
                     iter <= '0;
                     case (phase)
                        PH_FWD: begin
                           if (slot == SLOT_END) phase <= PH_MID;
                           else                  slot  <= slot + SLOT_W'(1);
                        end
                        PH_MID: phase <= PH_REV;
                        default: begin
                           if (slot == '0) phase <= PH_LAST;
                           else            slot  <= slot - SLOT_W'(1);
                        end
                     endcase
                  end else begin
                     iter <= iter + ITER_W'(1);
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/zz_scan_seq.sv
module zz_scan_seq
   import zz_scan_pkg::*;
#(
   parameter int GRID = 8,
   parameter int CW   = $clog2(GRID + 1),
   parameter int AW   = $clog2(GRID * GRID)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          ready,
   output logic [CW-1:0] x,
   output logic [CW-1:0] y,
   output logic [AW-1:0] addr,
   output logic          valid,
   output logic          done
);

   localparam int GROUPS    = (GRID - 2) / 2;
   localparam int LAST_SLOT = 4 * GROUPS;
   localparam int SLOT_W    = $clog2(LAST_SLOT + 1);
   localparam int ITER_W    = $clog2(GRID);
   localparam bit POW2      = (GRID & (GRID - 1)) == 0;

   generate
      if (GRID < 4 || (GRID % 2) != 0) begin : g_bad_grid
         $error("zz_scan_seq: GRID must be even and at least 4");
      end
      if (CW != $clog2(GRID + 1)) begin : g_bad_cw
         $error("zz_scan_seq: CW must hold the value GRID");
      end
      if (AW != $clog2(GRID * GRID)) begin : g_bad_aw
         $error("zz_scan_seq: AW must index GRID*GRID cells");
      end
   endgenerate

   phase_e            phase;
   logic [SLOT_W-1:0] slot;
   prim_e             slot_prim;
   prim_e             prim;
   logic              mirror;
   logic [CW-1:0]     nx;
   logic [CW-1:0]     ny;
   logic              edge_hit;

   zz_prim_decode #(.SLOT_W(SLOT_W)) u_decode (
      .slot (slot),
      .prim (slot_prim)
   );

   assign prim   = (phase == PH_MID) ? PRIM_SW : slot_prim;
   assign mirror = (phase == PH_REV);

   zz_step_unit #(.GRID(GRID), .CW(CW)) u_step (
      .x        (x),
      .y        (y),
      .prim     (prim),
      .mirror   (mirror),
      .nx       (nx),
      .ny       (ny),
      .edge_hit (edge_hit)
   );

   zz_seq_ctrl #(
      .GRID      (GRID),
      .CW        (CW),
      .SLOT_W    (SLOT_W),
      .ITER_W    (ITER_W),
      .LAST_SLOT (LAST_SLOT)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .ready    (ready),
      .prim     (prim),
      .nx       (nx),
      .ny       (ny),
      .edge_hit (edge_hit),
      .phase    (phase),
      .slot     (slot),
      .x        (x),
      .y        (y),
      .valid    (valid),
      .done     (done)
   );

   // Linear address: field concatenation for power-of-two grids
   logic [CW-1:0] x0;
   logic [CW-1:0] y0;
   assign x0 = x - CW'(1);
   assign y0 = y - CW'(1);

   generate
      if (POW2) begin : g_addr_cat
         localparam int LG = AW / 2;
         logic unused_hi;
         assign addr      = {y0[LG-1:0], x0[LG-1:0]};
         assign unused_hi = ^{x0[CW-1:LG], y0[CW-1:LG]};
      end else begin : g_addr_mul
         assign addr = AW'(int'(y0) * GRID + int'(x0));
      end
   endgenerate

endmodule

// File: rtl/zz_scan_seq_chk.sv
module zz_scan_seq_chk #(
   parameter int GRID = 8,
   parameter int CW   = 4,
   parameter int AW   = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          ready,
   input logic [CW-1:0] x,
   input logic [CW-1:0] y,
   input logic [AW-1:0] addr,
   input logic          valid,
   input logic          done
);

   logic [CW-1:0]   px;
   logic [CW-1:0]   py;
   logic signed [CW:0] dx;
   logic signed [CW:0] dy;
   logic            near;

   always_ff @(posedge clk) begin
      px <= x;
      py <= y;
   end

   always_comb begin
      dx   = $signed({1'b0, x}) - $signed({1'b0, px});
      dy   = $signed({1'b0, y}) - $signed({1'b0, py});
      near = (dx >= -1) && (dx <= 1) && (dy >= -1) && (dy <= 1) &&
             !((dx == 0) && (dy == 0));
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> !valid && !done);

   assert_start_corner_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !valid && start |=> valid && x == CW'(1) && y == CW'(1) && addr == '0);

   assert_coord_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> x >= CW'(1) && x <= CW'(GRID) && y >= CW'(1) && y <= CW'(GRID));

   assert_neighbour_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      valid && ready |=> !valid || near);

   assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !ready |=> valid && $stable(x) && $stable(y) && $stable(addr));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_no_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !valid);

   assert_done_after_corner_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(valid) && $past(ready) &&
                      $past(x) == CW'(GRID) && $past(y) == CW'(GRID));

endmodule

bind zz_scan_seq zz_scan_seq_chk #(.GRID(GRID), .CW(CW), .AW(AW)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start),
   .ready (ready),
   .x     (x),
   .y     (y),
   .addr  (addr),
   .valid (valid),
   .done  (done)
);

// File: tb/zz_scan_seq_tb.sv
module zz_scan_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int GRID       = 8;
   localparam int CELLS      = GRID * GRID;
   localparam int CW         = 4;
   localparam int AW         = 6;
   localparam int RUN_LIMIT  = 1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          ready = 1'b0;
   logic [CW-1:0] x;
   logic [CW-1:0] y;
   logic [AW-1:0] addr;
   logic          valid;
   logic          done;

   int checks = 0;
   int fails  = 0;
   int ref_x [CELLS];
   int ref_y [CELLS];
   int got_x [CELLS];
   int got_y [CELLS];
   int got_a [CELLS];

   always #(CLK_PERIOD / 2) clk = ~clk;

   zz_scan_seq #(.GRID(GRID)) u_dut (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .ready (ready),
      .x     (x),
      .y     (y),
      .addr  (addr),
      .valid (valid),
      .done  (done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Zigzag reference by diagonal sum: even sum x ascending, odd sum x descending
   task automatic build_ref();
      int n = 0;
      for (int d = 0; d <= 2 * GRID - 2; d++) begin
         for (int k = 0; k < GRID; k++) begin
            int cx = (d % 2 == 0) ? k : GRID - 1 - k;
            int cy = d - cx;
            if (cy >= 0 && cy < GRID) begin
               ref_x[n] = cx + 1;
               ref_y[n] = cy + 1;
               n++;
            end
         end
      end
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // mode 0: ready always high; 1: ready with gaps; 2: gaps plus stray starts
   task automatic run_scan(input int mode, input string tag);
      int  n = 0;
      int  cyc = 0;
      bit  stalled = 1'b0;
      int  px = 0;
      int  py = 0;
      int  addr_bad = 0;
      int  hold_bad = 0;
      int  near_bad = 0;
      int  order_bad = 0;
      int  first_bad = -1;
      bit  seen [CELLS];
      int  cover_cnt = 0;
      bit  r;
      pulse_start();
      chk(valid == 1'b1 && x == 1 && y == 1, "R2", {tag, " first beat at corner"},
          int'(x) * 16 + int'(y), 16 + 1);
      chk(addr == 0, "R2", {tag, " first address"}, int'(addr), 0);
      while (n < CELLS && cyc < RUN_LIMIT) begin
         r = (mode == 0) ? 1'b1 : !((cyc % 3) == 2 || (cyc >= 40 && cyc < 45));
         ready = r;
         start = (mode == 2 && n >= 10 && n < 14) ? 1'b1 : 1'b0;
         if (stalled && (int'(x) != px || int'(y) != py || !valid)) hold_bad++;
         if (valid && r) begin
            got_x[n] = int'(x);
            got_y[n] = int'(y);
            got_a[n] = int'(addr);
            n++;
         end
         stalled = valid && !r;
         px = int'(x);
         py = int'(y);
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      chk(cyc < RUN_LIMIT, "R6", {tag, " watchdog before 64 beats"}, cyc, RUN_LIMIT);
      chk(n == CELLS, "R6", {tag, " beat count"}, n, CELLS);
      if (mode == 0) chk(cyc == CELLS, "R7", {tag, " cycles at full rate"}, cyc, CELLS);
      else           chk(hold_bad == 0, "R7", {tag, " outputs held while stalled"}, hold_bad, 0);
      // R8: done the cycle after the corner beat, then gone
      chk(done == 1'b1 && valid == 1'b0, "R8", {tag, " done pulse with valid low"},
          int'(done) * 2 + int'(valid), 2);
      @(negedge clk);
      chk(done == 1'b0 && valid == 1'b0, "R8", {tag, " done lasts one cycle"},
          int'(done) * 2 + int'(valid), 0);
      for (int i = 0; i < n; i++) begin
         if (got_a[i] != (got_y[i] - 1) * GRID + (got_x[i] - 1) ||
             got_x[i] < 1 || got_x[i] > GRID || got_y[i] < 1 || got_y[i] > GRID)
            addr_bad++;
         if (got_x[i] != ref_x[i] || got_y[i] != ref_y[i]) begin
            order_bad++;
            if (first_bad < 0) first_bad = i;
         end
         if (i > 0) begin
            int ddx = got_x[i] - got_x[i-1];
            int ddy = got_y[i] - got_y[i-1];
            if (ddx < -1 || ddx > 1 || ddy < -1 || ddy > 1 || (ddx == 0 && ddy == 0))
               near_bad++;
         end
         if (got_x[i] >= 1 && got_x[i] <= GRID && got_y[i] >= 1 && got_y[i] <= GRID) begin
            if (!seen[(got_y[i] - 1) * GRID + got_x[i] - 1]) cover_cnt++;
            seen[(got_y[i] - 1) * GRID + got_x[i] - 1] = 1'b1;
         end
      end
      chk(addr_bad == 0, "R3", {tag, " address formula and range"}, addr_bad, 0);
      chk(near_bad == 0, "R4", {tag, " neighbour steps"}, near_bad, 0);
      if (first_bad >= 0)
         chk(1'b0, "R5", {tag, " zigzag order at beat (x*16+y)"},
             got_x[first_bad] * 16 + got_y[first_bad],
             ref_x[first_bad] * 16 + ref_y[first_bad]);
      else
         chk(1'b1, "R5", {tag, " zigzag order"}, 0, 0);
      chk(cover_cnt == CELLS, "R6", {tag, " distinct cells covered"}, cover_cnt, CELLS);
      chk(n > 0 && got_x[n-1] == GRID && got_y[n-1] == GRID, "R6", {tag, " last cell (x*16+y)"},
          (n > 0) ? got_x[n-1] * 16 + got_y[n-1] : 0, GRID * 16 + GRID);
      if (mode == 2) chk(order_bad == 0 && n == CELLS, "R9", {tag, " stray start ignored"},
                         order_bad, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      start = 1'b1;
      repeat (3) @(negedge clk);
      chk(valid == 1'b0 && done == 1'b0, "R1", "outputs low in reset",
          int'(valid) * 2 + int'(done), 0);
      start = 1'b0;
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(valid == 1'b0 && done == 1'b0, "R1", "idle after reset release",
          int'(valid) * 2 + int'(done), 0);
   endtask

   task automatic t_reset_mid_scan();
      ready = 1'b1;
      pulse_start();
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(valid == 1'b0 && done == 1'b0, "R1", "reset aborts a scan",
          int'(valid) * 2 + int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      build_ref();
      t_reset();
      run_scan(0, "full-rate");
      run_scan(1, "stalled");
      run_scan(2, "stray-start");
      // R10: a further start after done replays the same sequence
      run_scan(0, "replay R10");
      t_reset_mid_scan();
      run_scan(0, "after-abort");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule